// File: doc/BRIEF.md
# Host/Device Mailbox Ownership Semaphores

This block decides which of two parties may use each of a set of shared mailbox memories. The two parties are an external host, which reaches the block through byte-wide function registers, and an internal device processor, which has its own small byte port. Each mailbox has a 2-bit ownership field with three meanings: 2'b00 means free, 2'b01 means the host owns it, and 2'b11 means the device owns it. Either side asks for a mailbox by writing its own code. It then reads the field back to learn whether it got the mailbox.

If the host asks for a mailbox while the device holds it, the request is remembered as pending. When the device lets the mailbox go, ownership passes straight to the host in the same cycle. This handover also sets a sticky grant status bit. The bit drives a host interrupt, gated by one enable bit per mailbox and by a master enable input from the host-side protocol logic.

Host register offsets:
- 0x17 holds enables 7:0.
- 0x18 bits 2:0 hold enables 10:8.
- 0x19 bits 2:0 hold the grant status, cleared by writing 1.
- 0x1C, 0x1D and 0x1E hold the ownership fields of mailboxes 0, 1 and 2.

Top module: `mbx_sema_arb`

## Requirements
- R1: After reset, every ownership field reads 2'b00, every enable bit is 0, every grant status bit is 0, and host_irq is 0.
- R2: A host write of 2'b01 in bits 1:0 to a free mailbox's register (0x1C + index) makes the field read 2'b01 from the next cycle on. Bits 7:2 of every ownership register read 0, whatever was written to them.
- R3: A device write of 2'b11 in bits 1:0 to a free mailbox (dev_addr = index) makes the field read 2'b11 on both the host port and the device port.
- R4: When the host writes 2'b01 and the device writes 2'b11 to the same free mailbox in the same cycle, the host wins and the field becomes 2'b01.
- R5: A host write of 2'b01 while the device owns the mailbox leaves the field at 2'b11 and records a pending request. A later device write of 2'b00 moves the field directly to 2'b01, never passing through 2'b00.
- R6: That handover sets grant status bit [index] at offset 0x19. The bit stays set until the host writes a 1 to it; writing 0 to it has no effect.
- R7: A host write of 2'b00 to a mailbox the host does not own only cancels a pending host request. A later device release then leaves the field at 2'b00 and sets no status bit.
- R8: A host write of 2'b00 to a mailbox the host owns frees it (2'b00). A device write of 2'b00 or 2'b11 to a mailbox the host owns leaves it at 2'b01.
- R9: Enables 7:0 read and write at 0x17. Enables 10:8 are bits 2:0 of 0x18, and bits 7:3 of 0x18 read 0. host_irq equals irq_master_en AND the OR over i of (status[i] AND enable[8+i]).
- R10: Writes of code 2'b10 from either side, host writes of 2'b11 and device writes of 2'b01 never change a field, and the field never holds 2'b10.
- R11: The mailboxes act independently. A device read with dev_addr = 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr (combinational) |
| dev_we | input | 1 | Device write strobe |
| dev_addr | input | 2 | Mailbox index for the device port |
| dev_wdata | input | 8 | Device write data (bits 1:0 used) |
| dev_rdata | output | 8 | Ownership field of dev_addr, zero-extended |
| irq_master_en | input | 1 | Master interrupt enable from the host-side protocol logic |
| host_irq | output | 1 | Grant interrupt to the host |

## Verification
A wrong ownership state shows on host_rdata and dev_rdata in the first cycle after the write that caused it, because both read paths are combinational from the field registers. A lost or stale pending request stays hidden until the device releases the mailbox. It then shows at once, as a field of 2'b00 where 2'b01 was expected, or the reverse, and as a missing or extra status bit at 0x19. A wrong status or enable bit reaches host_irq in that same cycle. A status bit that does not hold is exposed by reading 0x19 after a write of 0s to it.

// File: rtl/mbx_sema_pkg.sv
package mbx_sema_pkg;
  localparam logic [1:0] SEM_FREE = 2'b00;
  localparam logic [1:0] SEM_HOST = 2'b01;
  localparam logic [1:0] SEM_BAD  = 2'b10;
  localparam logic [1:0] SEM_DEV  = 2'b11;

  // pending request survives unless cancelled this cycle
  function automatic logic pend_next(input logic pend, input logic h_req, input logic h_cancel);
    return (pend | h_req) & ~h_cancel;
  endfunction

  // sticky status: clear by 1, new grants win over clear
  function automatic logic [7:0] sticky_next(input logic [7:0] cur, input logic [7:0] clr,
                                             input logic [7:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/mbx_sema_cell.sv
module mbx_sema_cell
  import mbx_sema_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we_i,
  input  logic [1:0] host_val_i,
  input  logic       dev_we_i,
  input  logic [1:0] dev_val_i,
  output logic [1:0] sem_o,
  output logic       grant_o
);
  logic [1:0] sem_q, sem_d;
  logic       pend_q, pend_d;
  logic       h_req_w, h_rel_w, d_req_w, d_rel_w;
  logic       host_grab_w, dev_grab_w, handover_w;
  logic       pend_eff;

  assign h_req_w = host_we_i && (host_val_i == SEM_HOST);
  assign h_rel_w = host_we_i && (host_val_i == SEM_FREE);
  assign d_req_w = dev_we_i  && (dev_val_i  == SEM_DEV);
  assign d_rel_w = dev_we_i  && (dev_val_i  == SEM_FREE);
  assign pend_eff = pend_next(pend_q, h_req_w, h_rel_w);

  always_comb begin
    sem_d       = sem_q;
    pend_d      = pend_q;
    host_grab_w = 1'b0;
    dev_grab_w  = 1'b0;
    handover_w  = 1'b0;
    case (sem_q)
      SEM_FREE: begin
        pend_d = 1'b0;
        if (h_req_w) begin
          sem_d       = SEM_HOST;
          host_grab_w = 1'b1;
        end else if (d_req_w) begin
          sem_d      = SEM_DEV;
          dev_grab_w = 1'b1;
        end
      end
      SEM_HOST: begin
        pend_d = 1'b0;
        if (h_rel_w) sem_d = SEM_FREE;
      end
      SEM_DEV: begin
        if (d_rel_w) begin
          pend_d = 1'b0;
          if (pend_eff) begin
            sem_d      = SEM_HOST;
            handover_w = 1'b1;
          end else begin
            sem_d = SEM_FREE;
          end
        end else begin
          pend_d = pend_eff;
        end
      end
      default: begin
        sem_d  = SEM_FREE;
        pend_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sem_q  <= SEM_FREE;
      pend_q <= 1'b0;
    end else begin
      sem_q  <= sem_d;
      pend_q <= pend_d;
    end
  end

  assign sem_o   = sem_q;
  assign grant_o = handover_w;

  // R2
  host_grab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_grab_w |=> (sem_q == SEM_HOST));
  // R4
  host_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_q == SEM_FREE && h_req_w && d_req_w) |=> (sem_q != SEM_DEV));
  // R3
  dev_grab_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_grab_w |=> (sem_q == SEM_DEV));
  // R5
  pend_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (sem_q == SEM_DEV));
  // R5
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    handover_w |=> (sem_q == SEM_HOST && !pend_q));
  // R8
  host_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sem_q == SEM_HOST && h_rel_w) |=> (sem_q == SEM_FREE));
  // R10
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sem_q != SEM_BAD);
endmodule

// File: rtl/mbx_host_regs.sv
module mbx_host_regs #(
  parameter int ADDR_W   = 8,
  parameter int EN_W     = 11,
  parameter int NMBX     = 3,
  parameter int OFS_EN_LO = 'h17,
  parameter int OFS_EN_HI = 'h18,
  parameter int OFS_STS   = 'h19,
  parameter int OFS_SEM   = 'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [7:0]        host_wdata_i,
  input  logic [2*NMBX-1:0] sem_flat_i,
  input  logic [NMBX-1:0]   sts_i,
  output logic [EN_W-1:0]   en_o,
  output logic [NMBX-1:0]   sem_we_o,
  output logic [NMBX-1:0]   sts_clr_o,
  output logic [7:0]        host_rdata_o
);
  localparam int EN_HI_W = EN_W - 8;

  logic [7:0]         en_lo_q;
  logic [EN_HI_W-1:0] en_hi_q;
  logic               wr_lo_w, wr_hi_w, wr_sts_w;

  assign wr_lo_w  = host_we_i && (host_addr_i == ADDR_W'(OFS_EN_LO));
  assign wr_hi_w  = host_we_i && (host_addr_i == ADDR_W'(OFS_EN_HI));
  assign wr_sts_w = host_we_i && (host_addr_i == ADDR_W'(OFS_STS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_lo_q <= '0;
      en_hi_q <= '0;
    end else begin
      if (wr_lo_w) en_lo_q <= host_wdata_i;
      if (wr_hi_w) en_hi_q <= host_wdata_i[EN_HI_W-1:0];
    end
  end

  assign en_o      = {en_hi_q, en_lo_q};
  assign sts_clr_o = wr_sts_w ? host_wdata_i[NMBX-1:0] : '0;

  for (genvar i = 0; i < NMBX; i++) begin : g_dec
    assign sem_we_o[i] = host_we_i && (host_addr_i == ADDR_W'(OFS_SEM + i));
  end

  always_comb begin
    host_rdata_o = '0;
    if (host_addr_i == ADDR_W'(OFS_EN_LO)) host_rdata_o = en_lo_q;
    if (host_addr_i == ADDR_W'(OFS_EN_HI)) host_rdata_o[EN_HI_W-1:0] = en_hi_q;
    if (host_addr_i == ADDR_W'(OFS_STS))   host_rdata_o[NMBX-1:0] = sts_i;
    for (int i = 0; i < NMBX; i++) begin
      if (host_addr_i == ADDR_W'(OFS_SEM + i)) host_rdata_o[1:0] = sem_flat_i[2*i +: 2];
    end
  end

  // R9
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_lo_w || wr_hi_w) |=> $stable(en_o));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_sema_pkg::*;
#(
  parameter int NMBX = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NMBX-1:0] grant_i,
  input  logic [NMBX-1:0] clr_i,
  input  logic [NMBX-1:0] en_i,
  input  logic            master_en_i,
  output logic [NMBX-1:0] sts_o,
  output logic            irq_o
);
  logic [NMBX-1:0] sts_q;
  logic [7:0]      nxt_w;

  assign nxt_w = sticky_next(8'(sts_q), 8'(clr_i), 8'(grant_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= nxt_w[NMBX-1:0];
  end

  assign sts_o = sts_q;
  assign irq_o = master_en_i && |(sts_q & en_i);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts_q & ~clr_i)) |=> ((sts_q & $past(sts_q & ~clr_i)) == $past(sts_q & ~clr_i)));
  // R6
  grant_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_i) |=> ((sts_q & $past(grant_i)) == $past(grant_i)));
endmodule

// File: rtl/mbx_sema_arb.sv
module mbx_sema_arb
  import mbx_sema_pkg::*;
#(
  parameter int NMBX      = 3,
  parameter int EN_W      = 11,
  parameter int GRANT_BIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic [7:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       dev_we,
  input  logic [1:0] dev_addr,
  input  logic [7:0] dev_wdata,
  output logic [7:0] dev_rdata,
  input  logic       irq_master_en,
  output logic       host_irq
);
  logic [2*NMBX-1:0] sem_flat;
  logic [NMBX-1:0]   sem_we, dev_we_v, grant_v, sts, sts_clr;
  logic [EN_W-1:0]   en_vec;

  mbx_host_regs #(.ADDR_W(8), .EN_W(EN_W), .NMBX(NMBX)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_we_i(host_we), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .sem_flat_i(sem_flat), .sts_i(sts),
    .en_o(en_vec), .sem_we_o(sem_we), .sts_clr_o(sts_clr), .host_rdata_o(host_rdata)
  );

  for (genvar i = 0; i < NMBX; i++) begin : g_mbx
    assign dev_we_v[i] = dev_we && (dev_addr == 2'(i));
    mbx_sema_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .host_we_i(sem_we[i]), .host_val_i(host_wdata[1:0]),
      .dev_we_i(dev_we_v[i]), .dev_val_i(dev_wdata[1:0]),
      .sem_o(sem_flat[2*i +: 2]), .grant_o(grant_v[i])
    );
  end

  mbx_irq #(.NMBX(NMBX)) u_irq (
    .clk(clk), .rst_n(rst_n), .grant_i(grant_v), .clr_i(sts_clr),
    .en_i(en_vec[GRANT_BIT +: NMBX]), .master_en_i(irq_master_en),
    .sts_o(sts), .irq_o(host_irq)
  );

  always_comb begin
    dev_rdata = '0;
    for (int i = 0; i < NMBX; i++) begin
      if (dev_addr == 2'(i)) dev_rdata[1:0] = sem_flat[2*i +: 2];
    end
  end

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts == '0) |-> !host_irq);
endmodule

// File: tb/test_mbx_sema_arb.sv
module test_mbx_sema_arb;
  logic clk = 0, rst_n = 0;
  logic host_we = 0, dev_we = 0, irq_master_en = 0;
  logic [7:0] host_addr = 0, host_wdata = 0, dev_wdata = 0;
  logic [1:0] dev_addr = 0;
  logic [7:0] host_rdata, dev_rdata;
  logic host_irq;

  always #2 clk = ~clk;

  mbx_sema_arb i_mbx_sema_arb (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dev_we(dev_we),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
    .irq_master_en(irq_master_en), .host_irq(host_irq)
  );

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];
  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = sbq.pop_front();
      act = (it.kind == 0) ? host_rdata : (it.kind == 1) ? dev_rdata : {7'b0, host_irq};
      n_cmp++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic hw(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 0;
  endtask
  task automatic dw(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); dev_we = 1; dev_addr = a; dev_wdata = d;
    @(negedge clk); dev_we = 0;
  endtask
  task automatic both(input logic [7:0] ha, input logic [7:0] hd, input logic [1:0] da, input logic [7:0] dd);
    @(negedge clk); host_we = 1; host_addr = ha; host_wdata = hd;
    dev_we = 1; dev_addr = da; dev_wdata = dd;
    @(negedge clk); host_we = 0; dev_we = 0;
  endtask
  task automatic hr(input logic [7:0] a, input logic [7:0] e, input string t);
    item_t it;
    @(negedge clk); host_addr = a;
    it.kind = 0; it.exp = e; it.tag = t; sbq.push_back(it);
    @(negedge clk);
  endtask
  task automatic dr(input logic [1:0] a, input logic [7:0] e, input string t);
    item_t it;
    @(negedge clk); dev_addr = a;
    it.kind = 1; it.exp = e; it.tag = t; sbq.push_back(it);
    @(negedge clk);
  endtask
  task automatic ir(input logic e, input string t);
    item_t it;
    @(negedge clk);
    it.kind = 2; it.exp = {7'b0, e}; it.tag = t; sbq.push_back(it);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    hr(8'h1C, 8'h00, "R1"); hr(8'h1D, 8'h00, "R1"); hr(8'h1E, 8'h00, "R1");
    hr(8'h17, 8'h00, "R1"); hr(8'h18, 8'h00, "R1"); hr(8'h19, 8'h00, "R1");
    dr(2'd0, 8'h00, "R1"); ir(1'b0, "R1");
    // R2 host grab, reserved bits read zero
    hw(8'h1C, 8'hFD);
    hr(8'h1C, 8'h01, "R2"); dr(2'd0, 8'h01, "R2");
    // R8 device cannot take or free a host-owned box; host release frees
    dw(2'd0, 8'h03); hr(8'h1C, 8'h01, "R8");
    dw(2'd0, 8'h00); hr(8'h1C, 8'h01, "R8");
    hw(8'h1C, 8'h00); hr(8'h1C, 8'h00, "R8");
    // R3 device grab
    dw(2'd1, 8'h03); hr(8'h1D, 8'h03, "R3"); dr(2'd1, 8'h03, "R3");
    // R5 pending host request
    hw(8'h1D, 8'h01); hr(8'h1D, 8'h03, "R5"); hr(8'h19, 8'h00, "R5");
    // R9 enables
    hw(8'h17, 8'hA5); hw(8'h18, 8'hFF);
    hr(8'h17, 8'hA5, "R9"); hr(8'h18, 8'h07, "R9");
    irq_master_en = 1;
    ir(1'b0, "R9");
    dw(2'd1, 8'h00);
    dr(2'd1, 8'h01, "R5"); hr(8'h1D, 8'h01, "R5");
    hr(8'h19, 8'h02, "R6"); ir(1'b1, "R9");
    hw(8'h18, 8'h05); ir(1'b0, "R9");
    hw(8'h18, 8'h07); ir(1'b1, "R9");
    irq_master_en = 0; ir(1'b0, "R9");
    irq_master_en = 1;
    hw(8'h19, 8'h05); hr(8'h19, 8'h02, "R6"); ir(1'b1, "R6");
    hw(8'h19, 8'h02); hr(8'h19, 8'h00, "R6"); ir(1'b0, "R6");
    // R10 ignored codes on a host-owned box, then on a free box
    hw(8'h1D, 8'h02); hr(8'h1D, 8'h01, "R10");
    hw(8'h1D, 8'h03); hr(8'h1D, 8'h01, "R10");
    hw(8'h1D, 8'h00); hr(8'h1D, 8'h00, "R10");
    dw(2'd1, 8'h01); hr(8'h1D, 8'h00, "R10");
    dw(2'd1, 8'h02); dr(2'd1, 8'h00, "R10");
    hw(8'h1D, 8'h02); hr(8'h1D, 8'h00, "R10");
    // R7 cancelled pending request
    dw(2'd2, 8'h03); hw(8'h1E, 8'h01); hw(8'h1E, 8'h00);
    hr(8'h1E, 8'h03, "R7");
    dw(2'd2, 8'h00);
    hr(8'h1E, 8'h00, "R7"); hr(8'h19, 8'h00, "R7"); ir(1'b0, "R7");
    // R4 same-cycle requests
    both(8'h1C, 8'h01, 2'd0, 8'h03);
    hr(8'h1C, 8'h01, "R4"); dr(2'd0, 8'h01, "R4");
    // R11 independence
    dw(2'd2, 8'h03);
    hr(8'h1C, 8'h01, "R11"); hr(8'h1D, 8'h00, "R11"); hr(8'h1E, 8'h03, "R11");
    dr(2'd3, 8'h00, "R11");
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    wait (done || cyc > 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule